// File: doc/BRIEF.md
# DS3 M-Frame Parity Error Counter

This receive-side block checks parity on a DS3 stream that an upstream framer has already aligned. The framer supplies the serial data together with position markers. One marker says that the current bit is payload. One strobes each parity-bit position. One pulses at every M-frame boundary. A status flag reports loss of frame. The block XORs the payload bits of each M-frame into a running parity. It holds the two parity bits that arrive in the next M-frame. At the boundary that closes that next frame, it judges them against the parity it kept.

A failed judgement is one error event. It raises a single-cycle alarm pulse and adds one to a saturating live counter. A host strobe copies the live count into a holding register and clears the live count. An event that lands in the same cycle as the strobe is kept and starts the new count at one. A control input decides whether events are counted while loss of frame is asserted. In E3 mode the block makes no events and its count stays put.

Top module: `t3_parity_errcnt`

## Requirements
- R1: The frame parity is the XOR of `rx_data` over the cycles with `info_valid` high. `rx_data` in every other cycle has no effect on it.
- R2: If the first and second parity bits captured in a frame differ, an error event is declared at the boundary that closes that frame.
- R3: If the two captured parity bits are equal, an error event is declared exactly when they differ from the parity of the preceding M-frame.
- R4: A boundary yields at most one event, and the live count rises by at most one per cycle.
- R5: After reset, after a falling edge of `lof`, and after E3 mode is left, the first boundary makes no comparison.
- R6: With `cnt_inhibit_lof` = 1 an event seen while `lof` = 1 still pulses `err_pulse` but is not counted. With `cnt_inhibit_lof` = 0 it is counted.
- R7: While `e3_mode` = 1 no event is declared, `err_pulse` stays 0, and the live count holds.
- R8: The live count saturates at its all-ones value.
- R9: On `latch_strobe`, `held_count` takes the live count. The live count becomes 1 if an event is counted in that cycle and 0 otherwise.
- R10: `err_pulse` is high for the single cycle after the boundary that declared the event. The count changes on that same clock edge.
- R11: After reset `err_pulse`, `live_count` and `held_count` are 0.
- R12: A comparison is made only if at least two parity strobes were seen in the closing frame. Only the first two are used, and any further strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| e3_mode | input | 1 | 1 = E3 operation, checker idle |
| cnt_inhibit_lof | input | 1 | 1 = do not count events while lof is high |
| rx_data | input | 1 | Serial receive bit |
| info_valid | input | 1 | Current bit is a payload bit |
| pbit_strobe | input | 1 | Current bit is a parity bit |
| mframe_start | input | 1 | M-frame boundary pulse; carries no bit |
| lof | input | 1 | Loss-of-frame status |
| latch_strobe | input | 1 | Host transfer-and-clear strobe |
| err_pulse | output | 1 | One-cycle parity error pulse |
| live_count | output | CNT_W | Running saturating error count |
| held_count | output | CNT_W | Count captured at the last latch |

## Verification
The bench builds the block with `CNT_W` = 4. This lets a short run of bad frames reach saturation and check that the count holds at 15. Each frame carries eight payload bits, so the sweep covers all 256 payload words against all four parity-bit pairs. Inverted junk on the non-payload cycles covers R1. Further runs cover one and three strobes per frame, both loss-of-frame counting policies with the restart skip, and E3 entry and exit.

// File: rtl/t3par_pkg.sv
package t3par_pkg;
  localparam int unsigned PBITS_PER_FRAME = 2;
  localparam int unsigned PCNT_W = $clog2(PBITS_PER_FRAME + 1);

  typedef struct packed {
    logic first;
    logic second;
  } pbit_pair_t;
endpackage

// File: rtl/t3p_accum.sv
module t3p_accum
  import t3par_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_data,
  input  logic       info_valid,
  input  logic       pbit_strobe,
  input  logic       mframe_start,
  output logic       prev_par,
  output pbit_pair_t pbits,
  output logic       pbits_full
);
  localparam logic [PCNT_W-1:0] PFULL = PCNT_W'(PBITS_PER_FRAME);

  logic              acc;
  logic [PCNT_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= 1'b0;
      prev_par <= 1'b0;
      pcnt     <= '0;
      pbits    <= '0;
    end else if (mframe_start) begin
      prev_par <= acc;
      acc      <= 1'b0;
      pcnt     <= '0;
    end else begin
      if (info_valid) acc <= acc ^ rx_data;
      if (pbit_strobe && pcnt != PFULL) begin
        if (pcnt == '0) pbits.first  <= rx_data;
        else            pbits.second <= rx_data;
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign pbits_full = (pcnt == PFULL);
endmodule

// File: rtl/t3p_resync.sv
module t3p_resync (
  input  logic clk,
  input  logic rst,
  input  logic lof,
  input  logic e3_mode,
  input  logic mframe_start,
  output logic skip
);
  logic lof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lof_q <= 1'b0;
      skip  <= 1'b1;
    end else begin
      lof_q <= lof;
      if (e3_mode || (lof_q && !lof)) skip <= 1'b1;
      else if (mframe_start)          skip <= 1'b0;
    end
  end
endmodule

// File: rtl/t3p_counter.sv
module t3p_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] held
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else if (latch) begin
      held <= live;
      live <= inc ? CONE : '0;
    end else if (inc && live != CMAX) begin
      live <= live + CONE;
    end
  end
endmodule

// File: rtl/t3_parity_errcnt.sv
module t3_parity_errcnt
  import t3par_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             e3_mode,
  input  logic             cnt_inhibit_lof,
  input  logic             rx_data,
  input  logic             info_valid,
  input  logic             pbit_strobe,
  input  logic             mframe_start,
  input  logic             lof,
  input  logic             latch_strobe,
  output logic             err_pulse,
  output logic [CNT_W-1:0] live_count,
  output logic [CNT_W-1:0] held_count
);
  logic       prev_par;
  logic       pbits_full;
  logic       skip;
  pbit_pair_t pbits;
  logic       check_en, mismatch, err_evt, cnt_inc;

  t3p_accum u_accum (
    .clk(clk), .rst(rst), .rx_data(rx_data), .info_valid(info_valid),
    .pbit_strobe(pbit_strobe), .mframe_start(mframe_start),
    .prev_par(prev_par), .pbits(pbits), .pbits_full(pbits_full)
  );

  t3p_resync u_resync (
    .clk(clk), .rst(rst), .lof(lof), .e3_mode(e3_mode),
    .mframe_start(mframe_start), .skip(skip)
  );

  always_comb begin
    check_en = mframe_start && !skip && pbits_full && !e3_mode;
    mismatch = (pbits.first ^ pbits.second) | (pbits.first ^ prev_par);
    err_evt  = check_en && mismatch;
    cnt_inc  = err_evt && !(lof && cnt_inhibit_lof);
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= err_evt;
  end

  t3p_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .inc(cnt_inc), .latch(latch_strobe),
    .live(live_count), .held(held_count)
  );
endmodule

// File: rtl/t3p_parity_chk.sv
module t3p_parity_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             e3_mode,
  input logic             cnt_inhibit_lof,
  input logic             lof,
  input logic             latch_strobe,
  input logic             mframe_start,
  input logic             err_pulse,
  input logic [CNT_W-1:0] live_count,
  input logic [CNT_W-1:0] held_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse); // R10
  AST_PULSE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(mframe_start)); // R10
  AST_E3_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    e3_mode |=> !err_pulse); // R7
  AST_E3_HOLD: assert property (@(posedge clk) disable iff (rst)
    (e3_mode && !latch_strobe) |=> live_count == $past(live_count)); // R7
  AST_LOF_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (lof && cnt_inhibit_lof && !latch_strobe) |=> live_count == $past(live_count)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!latch_strobe && live_count == CMAX) |=> live_count == CMAX); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !latch_strobe |=> (live_count == $past(live_count)) ||
                      (live_count == CNT_W'($past(live_count) + 1'b1))); // R4
  AST_LATCH_XFER: assert property (@(posedge clk) disable iff (rst)
    latch_strobe |=> (held_count == $past(live_count)) && (live_count <= CNT_W'(1))); // R9
endmodule

bind t3_parity_errcnt t3p_parity_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .e3_mode(e3_mode), .cnt_inhibit_lof(cnt_inhibit_lof),
  .lof(lof), .latch_strobe(latch_strobe), .mframe_start(mframe_start),
  .err_pulse(err_pulse), .live_count(live_count), .held_count(held_count)
);

// File: tb/t3_parity_errcnt_bench.sv
`timescale 1ns/1ps
module t3_parity_errcnt_bench;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e3_mode = 1'b0, inh = 1'b0, rx = 1'b0, iv = 1'b0, ps = 1'b0;
  logic ms = 1'b0, lof = 1'b0, latch = 1'b0;
  logic err_pulse;
  logic [CW-1:0] live_count, held_count;

  always #2.5 clk = ~clk;

  t3_parity_errcnt #(.CNT_W(CW)) u_t3_parity_errcnt (
    .clk(clk), .rst(rst), .e3_mode(e3_mode), .cnt_inhibit_lof(inh),
    .rx_data(rx), .info_valid(iv), .pbit_strobe(ps), .mframe_start(ms),
    .lof(lof), .latch_strobe(latch), .err_pulse(err_pulse),
    .live_count(live_count), .held_count(held_count)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  int m_live = 0, m_held = 0, m_pn = 0;
  bit m_prev = 0, m_acc = 0, m_skip = 1, m_p0 = 0, m_p1 = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start(input bit lt);
    bit evt, cnt;
    string tag, ctag;
    evt = !e3_mode && !m_skip && (m_pn >= 2) && ((m_p0 != m_p1) || (m_p0 != m_prev));
    cnt = evt && !(lof && inh);
    if (e3_mode)          tag = "R7";
    else if (m_skip)      tag = "R5";
    else if (m_pn < 2)    tag = "R12";
    else if (m_p0 != m_p1) tag = "R2";
    else                  tag = "R1 R3";
    if (lt)                         ctag = "R9";
    else if (lof && inh && evt)     ctag = "R6";
    else if (cnt && m_live == CMAX) ctag = "R8";
    else                            ctag = "R4";
    ms = 1; latch = lt; iv = 0; ps = 0; rx = 0;
    cycle();
    ms = 0; latch = 0;
    if (lt) begin m_held = m_live; m_live = cnt ? 1 : 0; end
    else if (cnt && m_live < CMAX) m_live++;
    chk({tag, " err_pulse"}, err_pulse, evt);
    chk({ctag, " live_count"}, live_count, m_live);
    chk("R9 held_count", held_count, m_held);
    m_prev = m_acc; m_acc = 0; m_pn = 0;
    if (!e3_mode) m_skip = 0;
  endtask

  task automatic do_body(input bit [7:0] d, input bit p0, input bit p1,
                         input int nstr, input bit junk);
    for (int i = 0; i < 8; i++) begin
      iv = 0;
      ps = ((i == 1) && nstr >= 1) || ((i == 3) && nstr >= 2) || ((i == 5) && nstr >= 3);
      if (ps) begin
        rx = (i == 1) ? p0 : (i == 3) ? p1 : ~p0;
        if (m_pn == 0) m_p0 = rx; else if (m_pn == 1) m_p1 = rx;
        m_pn++;
      end else rx = ~d[i] ^ junk;
      cycle();
      if (i == 0) chk("R10 pulse width", err_pulse, 0);
      ps = 0; iv = 1; rx = d[i]; m_acc ^= d[i];
      cycle();
    end
    iv = 0;
  endtask

  task automatic set_lof(input bit v);
    if (lof && !v) m_skip = 1;
    lof = v;
    cycle();
  endtask

  task automatic set_e3(input bit v);
    e3_mode = v;
    if (v) m_skip = 1;
    cycle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run hung");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cycle();
    rst = 0;
    cycle();
    chk("R11 err_pulse", err_pulse, 0);
    chk("R11 live_count", live_count, 0);
    chk("R11 held_count", held_count, 0);

    // Exhaustive payload x parity-pair sweep with periodic latching (R1 R2 R3 R9)
    for (int d = 0; d < 256; d++) begin
      for (int pc = 0; pc < 4; pc++) begin
        do_start(((d * 4 + pc) % 5) == 4);
        do_body(8'(d), pc[0], pc[1], 2, d[1]);
      end
    end

    // Saturation without latching (R8)
    for (int k = 0; k < 24; k++) begin
      do_start(0);
      do_body(8'(k), 1'b0, 1'b1, 2, 1'b0);
    end
    do_start(1);
    do_body(8'h00, 1'b0, 1'b0, 2, 1'b1);

    // Strobe count: one strobe skips, three strobes use the first two (R12)
    for (int k = 0; k < 8; k++) begin
      do_start(0);
      do_body(8'(k * 37), k[0], k[1], (k < 4) ? 1 : 3, k[2]);
    end

    // LOF with counting inhibited, then allowed, then restart skip (R6 R5)
    for (int pol = 1; pol >= 0; pol--) begin
      inh = pol[0];
      set_lof(1);
      for (int k = 0; k < 6; k++) begin
        do_start(0);
        do_body(8'(k + 3), 1'b1, k[0], 2, 1'b0);
      end
      set_lof(0);
      for (int k = 0; k < 3; k++) begin
        do_start(0);
        do_body(8'h5A, 1'b1, 1'b0, 2, 1'b0);
      end
    end
    inh = 0;

    // E3 idle and exit skip (R7 R5)
    set_e3(1);
    for (int k = 0; k < 5; k++) begin
      do_start(k == 2);
      do_body(8'(k), 1'b0, 1'b1, 2, 1'b0);
    end
    set_e3(0);
    for (int k = 0; k < 4; k++) begin
      do_start(0);
      do_body(8'h81, 1'b1, 1'b0, 2, 1'b1);
    end
    do_start(1);

    done = 1;
    summary();
    $finish;
  end
endmodule